// File: doc/BRIEF.md
# Slave-Mode Trigger Timer

This block is an up-counter whose run/stop state is set by an external trigger line and not only by software. The trigger line is brought into the timer clock domain through a short register chain. A polarity select then qualifies it, and edge logic turns it into a single-cycle event. A 4-bit mode field decides how that event and the qualified level act on the counter:

- The counter can run only under a software enable.
- It can be started by the first active edge.
- It can be restarted from zero by every active edge, with an update pulse.
- It can count only while the qualified level is high, and it clears to zero when the level falls.

The counter climbs to a programmable limit and then wraps to zero. Each wrap raises a one-cycle update pulse. A sticky flag records active trigger edges. The mode field can be written directly. With the preload bit set, it can instead be written into a shadow copy that becomes active only when the counter wraps, so the mode can change at a clean period boundary while the counter runs.

Top module: `slave_trig_timer`

## Requirements
- R1: While rst_n is low, cnt, cnt_en, trig_flag and upd_pulse read 0, and mode_act and the shadow mode read 4'b0000.
- R2: While enabled and not overridden by the mode, cnt advances by one per clock up to arr_val. After arr_val it returns to 0, and upd_pulse is high for exactly the one cycle in which cnt reads 0 after the wrap.
- R3: In mode 4'b0000, and in every code not listed in R4, R8 and R9, cnt_en takes the value of sw_en one clock later.
- R4: In mode 4'b0110, an active trigger edge sets cnt_en. Nothing but reset or a mode change clears it, and sw_en has no effect.
- R5: An active level change on trig_in that is set up before clock edge k sets cnt_en at edge k+2. The first increment happens at edge k+3.
- R6: With trig_pol = 0 a rising trig_in edge is active. With trig_pol = 1 a falling edge is active and a rising edge is ignored.
- R7: trig_flag is set by every active edge in any mode. It is cleared by flag_clr, and a set in the same cycle as flag_clr wins.
- R8: In mode 4'b1000, an active edge clears cnt to 0, pulses upd_pulse and sets cnt_en in one clock. This applies also when the counter is already running.
- R9: In mode 4'b1001, cnt_en follows the qualified level (synchronised trig_in XOR trig_pol) and cnt advances only while it is high. When the level is low, cnt is 0 and cnt_en is 0 one clock later.
- R10: With mode_pe = 0, a mode_wr pulse makes mode_wdata the active mode (mode_act) one clock later.
- R11: With mode_pe = 1, a mode_wr pulse loads only the shadow. mode_act takes the shadow value only on a counter wrap, and not on the R8 restart update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | input | 1 | Software counter enable (used when the slave controller is off) |
| trig_in | input | 1 | External trigger line, asynchronous |
| trig_pol | input | 1 | 0: rising edge / high level active; 1: falling edge / low level active |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | Mode value to write |
| mode_pe | input | 1 | Mode preload enable |
| arr_val | input | CNT_W | Wrap limit of the counter |
| flag_clr | input | 1 | Clears the trigger flag |
| cnt | output | CNT_W | Counter value |
| cnt_en | output | 1 | Counter enable state |
| trig_flag | output | 1 | Sticky trigger flag |
| upd_pulse | output | 1 | One-cycle update event |
| mode_act | output | 4 | Active mode field |

## Verification
The assertions check the following on every cycle:
- cnt is zero whenever the update pulse is high.
- An enable set in trigger mode persists.
- A low gate level clears both the count and the enable.
- The active mode holds still under preload except at a wrap.
- Every active edge leaves the flag set.

Only the bench's scenarios can show the following:
- The exact two-cycle synchroniser latency.
- The polarity swap of the qualifying edge.
- The restart of a running counter on a repeated edge.
- The deferred mode change landing on the wrap cycle.

These are compared against a behavioural model on every clock.

// File: rtl/slvt_pkg.sv
package slvt_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF   = 4'b0000,
    SM_TRIG  = 4'b0110,
    SM_RTRIG = 4'b1000,
    SM_RGATE = 4'b1001
  } slv_mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic pol,
  output logic lvl,
  output logic edge_p
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q, chain_n;

  always_comb begin
    chain_n = {chain_q[CHAIN_W-2:0], trig_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  // qualified level from the last synchroniser stage, previous value one stage on
  assign lvl    = chain_q[SYNC_STAGES-1] ^ pol;
  assign edge_p = lvl & ~(chain_q[SYNC_STAGES] ^ pol);
endmodule

// File: rtl/mode_reg.sv
module mode_reg
  import slvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              pe,
  input  logic              wrap,
  output logic [MODE_W-1:0] act
);
  logic [MODE_W-1:0] sh_q, sh_n, act_q, act_n;

  always_comb begin
    sh_n  = wr ? wdata : sh_q;
    act_n = act_q;
    if (!pe) begin
      if (wr) act_n = wdata;
    end else if (wrap) begin
      act_n = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_n;
      act_q <= act_n;
    end
  end

  assign act = act_q;

  // R11
  pe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && !wrap) |=> $stable(act_q));
endmodule

// File: rtl/count_core.sv
module count_core
  import slvt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              sw_en,
  input  logic              edge_p,
  input  logic              lvl,
  input  logic [CW-1:0]     arr,
  output logic [CW-1:0]     cnt,
  output logic              en,
  output logic              upd,
  output logic              wrap
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          en_q, en_n, upd_q, upd_n, adv;

  always_comb begin
    cnt_n = cnt_q;
    en_n  = en_q;
    upd_n = 1'b0;
    wrap  = 1'b0;
    adv   = 1'b0;
    case (mode)
      SM_TRIG: begin
        en_n = en_q | edge_p;
        adv  = 1'b1;
      end
      SM_RTRIG: begin
        en_n = en_q | edge_p;
        if (edge_p) begin
          cnt_n = '0;
          upd_n = 1'b1;
        end else begin
          adv = 1'b1;
        end
      end
      SM_RGATE: begin
        en_n = lvl;
        if (!lvl) cnt_n = '0;
        else      adv   = 1'b1;
      end
      default: begin
        en_n = sw_en;
        adv  = 1'b1;
      end
    endcase
    if (adv && en_q) begin
      wrap  = (cnt_q == arr);
      cnt_n = wrap ? '0 : cnt_q + ONE;
      upd_n = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      en_q  <= en_n;
      upd_q <= upd_n;
    end
  end

  assign cnt = cnt_q;
  assign en  = en_q;
  assign upd = upd_q;

  // R2
  upd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (cnt_q == '0));
  // R4
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_TRIG && en_q) |=> en_q);
  // R9
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_RGATE && !lvl) |=> (cnt_q == '0 && !en_q));
endmodule

// File: rtl/slave_trig_timer.sv
module slave_trig_timer
  import slvt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              trig_in,
  input  logic              trig_pol,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              mode_pe,
  input  logic [CNT_W-1:0]  arr_val,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_en,
  output logic              trig_flag,
  output logic              upd_pulse,
  output logic [MODE_W-1:0] mode_act
);
  logic lvl, edge_p, wrap;
  logic flag_q, flag_n;

  trig_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pol(trig_pol),
    .lvl(lvl), .edge_p(edge_p)
  );

  mode_reg mode_i (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(mode_wdata),
    .pe(mode_pe), .wrap(wrap), .act(mode_act)
  );

  count_core #(.CW(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_act), .sw_en(sw_en),
    .edge_p(edge_p), .lvl(lvl), .arr(arr_val),
    .cnt(cnt), .en(cnt_en), .upd(upd_pulse), .wrap(wrap)
  );

  always_comb begin
    flag_n = edge_p | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  assign trig_flag = flag_q;

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_p |=> flag_q);
endmodule

// File: tb/slave_trig_timer_tb.sv
module slave_trig_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_en = 1'b0, trig_in = 1'b0, trig_pol = 1'b0;
  logic          mode_wr = 1'b0, mode_pe = 1'b0, flag_clr = 1'b0;
  logic [3:0]    mode_wdata = 4'd0;
  logic [CW-1:0] arr_val = 16'd5;
  logic [CW-1:0] cnt;
  logic          cnt_en, trig_flag, upd_pulse;
  logic [3:0]    mode_act;

  int checks = 0, errors = 0, cycles = 0;

  slave_trig_timer dut_i (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .trig_in(trig_in),
    .trig_pol(trig_pol), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mode_pe(mode_pe), .arr_val(arr_val), .flag_clr(flag_clr),
    .cnt(cnt), .cnt_en(cnt_en), .trig_flag(trig_flag),
    .upd_pulse(upd_pulse), .mode_act(mode_act)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_cnt, m_act, m_sh;
  bit m_en, m_flag, m_upd;
  bit hq[$];

  always @(posedge clk or negedge rst_n) begin
    bit s2, s3, lv, ed, cnt_on, wr_hit;
    int nc, na;
    bit ne, nu;
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_sh = 0; m_en = 0; m_flag = 0; m_upd = 0;
      hq.delete();
    end else begin
      s2 = (hq.size() > 1) ? hq[1] : 1'b0;
      s3 = (hq.size() > 2) ? hq[2] : 1'b0;
      lv = s2 ^ trig_pol;
      ed = lv && !(s3 ^ trig_pol);
      nc = m_cnt; ne = m_en; nu = 0; cnt_on = 0; wr_hit = 0;
      if (m_act == 6) begin
        ne = m_en | ed; cnt_on = 1;
      end else if (m_act == 8) begin
        ne = m_en | ed;
        if (ed) begin nc = 0; nu = 1; end else cnt_on = 1;
      end else if (m_act == 9) begin
        ne = lv;
        if (!lv) nc = 0; else cnt_on = 1;
      end else begin
        ne = sw_en; cnt_on = 1;
      end
      if (cnt_on && m_en) begin
        if (m_cnt == int'(arr_val)) begin nc = 0; nu = 1; wr_hit = 1; end
        else nc = m_cnt + 1;
      end
      na = m_act;
      if (!mode_pe) begin
        if (mode_wr) na = int'(mode_wdata);
      end else if (wr_hit) na = m_sh;
      if (mode_wr) m_sh = int'(mode_wdata);
      m_flag = ed | (m_flag & !flag_clr);
      m_cnt = nc; m_en = ne; m_upd = nu; m_act = na;
      hq.push_front(trig_in);
      if (hq.size() > 3) void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (int'(cnt) != m_cnt || cnt_en != m_en || trig_flag != m_flag ||
          upd_pulse != m_upd || int'(mode_act) != m_act) begin
        errors++;
        $display("FAIL R2/R4/R7/R8/R10 model cycle %0d: cnt %0d/%0d en %0b/%0b flag %0b/%0b upd %0b/%0b mode %0d/%0d",
                 cycles, cnt, m_cnt, cnt_en, m_en, trig_flag, m_flag,
                 upd_pulse, m_upd, mode_act, m_act);
      end
    end
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [3:0] v, input bit pe);
    mode_pe = pe; mode_wdata = v; mode_wr = 1'b1;
    step(1);
    mode_wr = 1'b0;
  endtask

  initial begin
    int c0, prev, seen;
    step(3);
    // R1 reset state
    chk(cnt == 0 && !cnt_en && !trig_flag && !upd_pulse, "R1 outputs", int'(cnt), 0);
    chk(mode_act == 0, "R1 mode", int'(mode_act), 0);
    rst_n = 1'b1;

    // R3 software enable
    sw_en = 1'b1;
    step(1);
    chk(cnt_en == 1'b1, "R3 enable follows sw_en", int'(cnt_en), 1);
    // R2 wrap at arr_val
    seen = 0; prev = int'(cnt);
    for (int i = 0; i < 20 && !seen; i++) begin
      step(1);
      if (upd_pulse) begin
        seen = 1;
        chk(cnt == 0, "R2 cnt zero on update", int'(cnt), 0);
        chk(prev == 5, "R2 value before wrap", prev, 5);
      end
      prev = int'(cnt);
    end
    chk(seen == 1, "R2 update seen", seen, 1);
    step(1);
    chk(upd_pulse == 1'b0, "R2 single-cycle update", int'(upd_pulse), 0);
    sw_en = 1'b0;
    step(1);
    chk(cnt_en == 1'b0, "R3 enable drops", int'(cnt_en), 0);

    // R10 immediate mode write, R4 sw_en ignored in trigger mode
    wr_mode(4'b0110, 1'b0);
    chk(mode_act == 4'b0110, "R10 mode applied", int'(mode_act), 6);
    sw_en = 1'b1;
    step(3);
    chk(cnt_en == 1'b0, "R4 sw_en ignored", int'(cnt_en), 0);
    sw_en = 1'b0;

    // R5 latency
    c0 = int'(cnt);
    trig_in = 1'b1;
    step(2);
    chk(cnt_en == 1'b0, "R5 not yet enabled", int'(cnt_en), 0);
    step(1);
    chk(cnt_en == 1'b1, "R5 enabled at k+2", int'(cnt_en), 1);
    chk(trig_flag == 1'b1, "R7 flag set", int'(trig_flag), 1);
    chk(int'(cnt) == c0, "R5 no increment yet", int'(cnt), c0);
    step(1);
    chk(int'(cnt) == ((c0 == 5) ? 0 : c0 + 1), "R5 first increment", int'(cnt), (c0 == 5) ? 0 : c0 + 1);
    trig_in = 1'b0;
    step(4);
    chk(cnt_en == 1'b1, "R4 enable held", int'(cnt_en), 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk(trig_flag == 1'b0, "R7 flag cleared", int'(trig_flag), 0);

    // R6 polarity
    trig_pol = 1'b1; step(4);
    trig_in = 1'b1; step(4);
    chk(trig_flag == 1'b0, "R6 rising ignored", int'(trig_flag), 0);
    trig_in = 1'b0; step(4);
    chk(trig_flag == 1'b1, "R6 falling active", int'(trig_flag), 1);
    trig_pol = 1'b0; step(4);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;

    // R8 restart while running
    arr_val = 16'd200;
    wr_mode(4'b1000, 1'b0);
    step(6);
    trig_in = 1'b1;
    step(3);
    chk(cnt == 0 && upd_pulse && cnt_en, "R8 restart running", int'(cnt), 0);
    step(1);
    chk(cnt == 1, "R8 counts after restart", int'(cnt), 1);
    trig_in = 1'b0; step(3);
    wr_mode(4'b0000, 1'b0); step(2);
    chk(cnt_en == 1'b0, "R3 stopped", int'(cnt_en), 0);
    wr_mode(4'b1000, 1'b0);
    trig_in = 1'b1; step(3);
    chk(cnt == 0 && upd_pulse && cnt_en, "R8 start from stop", int'(cnt_en), 1);
    trig_in = 1'b0; step(3);

    // R9 gated
    wr_mode(4'b1001, 1'b0); step(2);
    chk(cnt == 0 && !cnt_en, "R9 gate low idle", int'(cnt), 0);
    trig_in = 1'b1; step(3);
    chk(cnt_en == 1'b1, "R9 gate opens", int'(cnt_en), 1);
    step(4);
    chk(cnt == 4, "R9 counting", int'(cnt), 4);
    trig_in = 1'b0; step(3);
    chk(cnt == 0 && !cnt_en, "R9 gate close resets", int'(cnt), 0);

    // R11 preload applied on wrap
    arr_val = 16'd5; sw_en = 1'b1; trig_in = 1'b1; step(3);
    wr_mode(4'b0000, 1'b1);
    chk(mode_act == 4'b1001, "R11 held in shadow", int'(mode_act), 9);
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      step(1);
      if (upd_pulse) begin
        seen = 1;
        chk(mode_act == 4'b0000, "R11 loaded on wrap", int'(mode_act), 0);
      end else begin
        chk(mode_act == 4'b1001, "R11 stable before wrap", int'(mode_act), 9);
      end
    end
    chk(seen == 1, "R11 wrap seen", seen, 1);
    step(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule